// File: doc/BRIEF.md
# Nametable RAM Address Mirroring Unit

This block watches the 14-bit address bus of a video processor and produces the chip enable, the 11-bit address and the read and write strobes for a 2 KB by 8 nametable SRAM. The low ten RAM address bits follow the video address directly. The top RAM address bit comes from a run-time mirroring selection. It can follow video address bit 10, follow video address bit 11, or be held at 0 or at 1. These four settings give vertical, horizontal or single-screen arrangements of the four logical nametables on the two physical ones.

The RAM is enabled only while the video address falls inside an enable window. The normal window covers 0x2000 to 0x3EFF. A wide window can be selected instead, which covers every address from 0x0000 to 0x3EFF. The palette page, 0x3F00 to 0x3FFF, never enables the RAM. A cartridge-side disable input turns the RAM off completely, which suits boards that bring their own nametable memory or ROM. All outputs are registered, so each output reflects the inputs sampled one clock earlier.

Top module: `nt_mirror_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: One cycle after any input cycle, `ram_addr[9:0]` equals `vaddr[9:0]` from that cycle.
- R3: With `mir_mode` = 2'b00 (vertical), `ram_addr[10]` equals the previous cycle's `vaddr[10]`.
- R4: With `mir_mode` = 2'b01 (horizontal), `ram_addr[10]` equals the previous cycle's `vaddr[11]`.
- R5: With `mir_mode` = 2'b10, `ram_addr[10]` is 0. With `mir_mode` = 2'b11, it is 1. No video address bit has any effect on it in these two modes.
- R6: With `wide_win` low and `int_off` low, `ram_ce` is 1 exactly when the previous cycle's `vaddr` lies in 0x2000..0x3EFF.
- R7: With `wide_win` high and `int_off` low, `ram_ce` is 1 exactly when the previous cycle's `vaddr` lies in 0x0000..0x3EFF.
- R8: A previous-cycle `vaddr` in 0x3F00..0x3FFF always gives `ram_ce` = 0, whatever the window setting.
- R9: With `int_off` high in the previous cycle, `ram_ce`, `ram_oe` and `ram_we` are 0, whatever the address and strobes.
- R10: `ram_oe` equals the previous cycle's `vrd` AND the enable, and `ram_we` equals the previous cycle's `vwr` AND the enable. Neither strobe is ever 1 while `ram_ce` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 14 | Video processor address |
| vrd | input | 1 | Video read strobe, active high |
| vwr | input | 1 | Video write strobe, active high |
| mir_mode | input | 2 | Mirroring: 00 bit 10, 01 bit 11, 10 fixed 0, 11 fixed 1 |
| int_off | input | 1 | Cartridge disable of the internal RAM |
| wide_win | input | 1 | 1 selects the 0x0000..0x3EFF window |
| ram_ce | output | 1 | RAM chip enable, active high |
| ram_addr | output | 11 | RAM address |
| ram_oe | output | 1 | RAM read enable, active high |
| ram_we | output | 1 | RAM write enable, active high |

## Verification
The hardest case to reach is the window boundaries, 0x1FFF/0x2000 and 0x3EFF/0x3F00, in combination with each window setting and with the disable input. A uniformly random 14-bit address rarely lands on these values. The stimulus therefore draws addresses from weighted regions, and one region is the boundary addresses plus or minus one. It also applies directed vectors at every edge under both windows, with the disable input both low and high. Read and write strobes are raised together on some palette-page and disabled vectors. This shows that neither strobe leaks through when the enable is low.

// File: rtl/nt_mirror_pkg.sv
package nt_mirror_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'b00,
    MIR_HORZ   = 2'b01,
    MIR_ONE_LO = 2'b10,
    MIR_ONE_HI = 2'b11
  } mir_mode_e;

  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
  } ram_ctl_t;

endpackage

// File: rtl/nt_window_decode.sv
module nt_window_decode #(
  parameter int VA_W     = 14,
  parameter int NT_BASE  = 'h2000,
  parameter int PAL_BASE = 'h3F00
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            wide_win,
  input  logic            int_off,
  output logic            hit
);

  localparam logic [VA_W-1:0] LOW_EDGE  = VA_W'(NT_BASE);
  localparam logic [VA_W-1:0] HIGH_EDGE = VA_W'(PAL_BASE - 1);

  logic below_pal;
  logic above_low;

  always_comb begin
    below_pal = (vaddr <= HIGH_EDGE);
    above_low = wide_win || (vaddr >= LOW_EDGE);
    hit       = below_pal && above_low && !int_off;
  end

endmodule

// File: rtl/nt_bank_select.sv
module nt_bank_select
  import nt_mirror_pkg::*;
(
  input  logic      bit_vert,
  input  logic      bit_horz,
  input  mir_mode_e mode,
  output logic      bank
);

  always_comb begin
    unique case (mode)
      MIR_VERT:   bank = bit_vert;
      MIR_HORZ:   bank = bit_horz;
      MIR_ONE_LO: bank = 1'b0;
      MIR_ONE_HI: bank = 1'b1;
      default:    bank = 1'b0;
    endcase
  end

endmodule

// File: rtl/nt_out_reg.sv
module nt_out_reg
  import nt_mirror_pkg::*;
#(
  parameter int RA_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] addr_d,
  input  ram_ctl_t        ctl_d,
  output logic [RA_W-1:0] addr_q,
  output ram_ctl_t        ctl_q
);

  for (genvar i = 0; i < RA_W; i++) begin : g_abit
    always_ff @(posedge clk) begin
      if (rst) addr_q[i] <= 1'b0;
      else     addr_q[i] <= addr_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

endmodule

// File: rtl/nt_mirror_unit.sv
module nt_mirror_unit
  import nt_mirror_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int RA_W      = 11,
  parameter int NT_BASE   = 'h2000,
  parameter int PAL_BASE  = 'h3F00,
  parameter int VERT_BIT  = 10,
  parameter int HORZ_BIT  = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VA_W-1:0] vaddr,
  input  logic            vrd,
  input  logic            vwr,
  input  logic [1:0]      mir_mode,
  input  logic            int_off,
  input  logic            wide_win,
  output logic            ram_ce,
  output logic [RA_W-1:0] ram_addr,
  output logic            ram_oe,
  output logic            ram_we
);

  localparam int PASS_W = RA_W - 1;
  localparam logic [VA_W-1:0] PAL_EDGE = VA_W'(PAL_BASE);
  localparam logic [VA_W-1:0] NT_EDGE  = VA_W'(NT_BASE);
  localparam logic [VA_W-1:0] TOP_OK   = VA_W'(PAL_BASE - 1);

  logic            hit;
  logic            bank;
  logic [RA_W-1:0] addr_d;
  ram_ctl_t        ctl_d;
  ram_ctl_t        ctl_q;

  nt_window_decode #(
    .VA_W(VA_W), .NT_BASE(NT_BASE), .PAL_BASE(PAL_BASE)
  ) u_win (
    .vaddr(vaddr), .wide_win(wide_win), .int_off(int_off), .hit(hit)
  );

  nt_bank_select u_bank (
    .bit_vert(vaddr[VERT_BIT]),
    .bit_horz(vaddr[HORZ_BIT]),
    .mode(mir_mode_e'(mir_mode)),
    .bank(bank)
  );

  always_comb begin
    addr_d  = {bank, vaddr[PASS_W-1:0]};
    ctl_d.ce = hit;
    ctl_d.oe = hit & vrd;
    ctl_d.we = hit & vwr;
  end

  nt_out_reg #(.RA_W(RA_W)) u_oreg (
    .clk(clk), .rst(rst), .addr_d(addr_d), .ctl_d(ctl_d),
    .addr_q(ram_addr), .ctl_q(ctl_q)
  );

  assign ram_ce = ctl_q.ce;
  assign ram_oe = ctl_q.oe;
  assign ram_we = ctl_q.we;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ram_ce && !ram_oe && !ram_we && ram_addr == '0)); // R1
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ram_addr[PASS_W-1:0] == $past(vaddr[PASS_W-1:0])); // R2
  AST_VERT_BIT: assert property (@(posedge clk) disable iff (rst)
    (mir_mode == 2'b00) |=> ram_addr[RA_W-1] == $past(vaddr[VERT_BIT])); // R3
  AST_HORZ_BIT: assert property (@(posedge clk) disable iff (rst)
    (mir_mode == 2'b01) |=> ram_addr[RA_W-1] == $past(vaddr[HORZ_BIT])); // R4
  AST_SINGLE_LO: assert property (@(posedge clk) disable iff (rst)
    (mir_mode == 2'b10) |=> !ram_addr[RA_W-1]); // R5
  AST_SINGLE_HI: assert property (@(posedge clk) disable iff (rst)
    (mir_mode == 2'b11) |=> ram_addr[RA_W-1]); // R5
  AST_NORMAL_WIN: assert property (@(posedge clk) disable iff (rst)
    (!wide_win && !int_off && vaddr >= NT_EDGE && vaddr <= TOP_OK) |=> ram_ce); // R6
  AST_BELOW_WIN: assert property (@(posedge clk) disable iff (rst)
    (!wide_win && vaddr < NT_EDGE) |=> !ram_ce); // R6
  AST_WIDE_WIN: assert property (@(posedge clk) disable iff (rst)
    (wide_win && !int_off && vaddr <= TOP_OK) |=> ram_ce); // R7
  AST_PAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (vaddr >= PAL_EDGE) |=> !ram_ce); // R8
  AST_DISABLED: assert property (@(posedge clk) disable iff (rst)
    int_off |=> (!ram_ce && !ram_oe && !ram_we)); // R9
  AST_RD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ram_oe == ($past(vrd) && ram_ce)); // R10
  AST_WR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ram_we == ($past(vwr) && ram_ce)); // R10

endmodule

// File: tb/sim_nt_mirror_unit.sv
`timescale 1ns/1ps
module sim_nt_mirror_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] vaddr;
  logic        vrd, vwr;
  logic [1:0]  mir_mode;
  logic        int_off, wide_win;
  logic        ram_ce, ram_oe, ram_we;
  logic [10:0] ram_addr;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  nt_mirror_unit u0 (
    .clk(clk), .rst(rst), .vaddr(vaddr), .vrd(vrd), .vwr(vwr),
    .mir_mode(mir_mode), .int_off(int_off), .wide_win(wide_win),
    .ram_ce(ram_ce), .ram_addr(ram_addr), .ram_oe(ram_oe), .ram_we(ram_we)
  );

  function automatic logic exp_ce(logic [13:0] a, logic w, logic off);
    if (off) return 1'b0;
    if (a >= 14'h3F00) return 1'b0;
    if (w) return 1'b1;
    return (a >= 14'h2000);
  endfunction

  function automatic logic exp_bank(logic [13:0] a, logic [1:0] m);
    case (m)
      2'b00: return a[10];
      2'b01: return a[11];
      2'b10: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string ce_req(logic [13:0] a, logic w, logic off);
    if (off) return "R9";
    if (a >= 14'h3F00) return "R8";
    return w ? "R7" : "R6";
  endfunction

  function automatic string bank_req(logic [1:0] m);
    if (m == 2'b00) return "R3";
    if (m == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [13:0] a, input logic [1:0] m, input logic w,
                       input logic off, input logic r, input logic wr);
    logic ce_e;
    vaddr = a; mir_mode = m; wide_win = w; int_off = off; vrd = r; vwr = wr;
    @(negedge clk);
    ce_e = exp_ce(a, w, off);
    check(ram_ce == ce_e, ce_req(a, w, off), "ce", 16'(ram_ce), 16'(ce_e));
    check(ram_addr[9:0] == a[9:0], "R2", "addr_lo", 16'(ram_addr[9:0]), 16'(a[9:0]));
    check(ram_addr[10] == exp_bank(a, m), bank_req(m), "bank",
          16'(ram_addr[10]), 16'(exp_bank(a, m)));
    check(ram_oe == (r & ce_e), off ? "R9" : "R10", "oe", 16'(ram_oe), 16'(r & ce_e));
    check(ram_we == (wr & ce_e), off ? "R9" : "R10", "we", 16'(ram_we), 16'(wr & ce_e));
  endtask

  function automatic logic [13:0] pick_addr();
    logic [13:0] edges [8] = '{14'h0000, 14'h1FFF, 14'h2000, 14'h2001,
                               14'h3EFE, 14'h3EFF, 14'h3F00, 14'h3FFF};
    case ($urandom % 4)
      0: return edges[$urandom % 8];
      1: return 14'h2000 | 14'($urandom % 14'h1F00);
      2: return 14'h3F00 | 14'($urandom % 256);
      default: return 14'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1187));
    rst = 1'b1; vaddr = 14'h2400; mir_mode = 2'b11; wide_win = 1'b1;
    int_off = 1'b0; vrd = 1'b1; vwr = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs stay low during reset even with active inputs
    check(ram_ce == 1'b0 && ram_oe == 1'b0 && ram_we == 1'b0, "R1", "ctl",
          16'({ram_ce, ram_oe, ram_we}), 16'h0);
    check(ram_addr == 11'h0, "R1", "addr", 16'(ram_addr), 16'h0);
    rst = 1'b0;

    // Directed boundaries, both windows, every mode
    for (int w = 0; w < 2; w++) begin
      for (int m = 0; m < 4; m++) begin
        apply(14'h1FFF, 2'(m), 1'(w), 1'b0, 1'b1, 1'b0); // R6/R7 lower edge
        apply(14'h2000, 2'(m), 1'(w), 1'b0, 1'b0, 1'b1);
        apply(14'h2C00, 2'(m), 1'(w), 1'b0, 1'b1, 1'b1); // R3/R4 bits 10/11 set
        apply(14'h2800, 2'(m), 1'(w), 1'b0, 1'b1, 1'b0);
        apply(14'h3EFF, 2'(m), 1'(w), 1'b0, 1'b1, 1'b1);
        apply(14'h3F00, 2'(m), 1'(w), 1'b0, 1'b1, 1'b1); // R8
        apply(14'h3FFF, 2'(m), 1'(w), 1'b0, 1'b1, 1'b1); // R8
        apply(14'h0000, 2'(m), 1'(w), 1'b0, 1'b1, 1'b1); // R7 wide start
        apply(14'h2400, 2'(m), 1'(w), 1'b1, 1'b1, 1'b1); // R9
      end
    end

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      apply(pick_addr(), 2'($urandom), 1'($urandom), ($urandom % 8) == 0,
            1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule